// File: doc/BRIEF.md
# Display Fault Recovery Sequencer

This block supervises a display module through two timeout stages and turns their faults into recovery actions. A fast stage watches for per-frame kicks, and it accepts a kick only when the frame's integrity check passes in the same cycle. A missing kick, or a fault reported by an external fast monitor, starts a local recovery. That recovery switches the backlight off, waits, pulses the display-controller reset, waits again and switches the backlight back on. A slow stage watches a separate health kick. When that kick stops arriving, the block issues a full-system reset instead.

All timing is counted in ticks, which are single-cycle strobes from a shared timebase, so the timeouts do not depend on the clock rate. Each reset the block starts is counted in a rolling window. If a fault arrives while the budget is used up, the block starts no further reset and locks into a safe mode. In safe mode both stages are ignored and a flag tells the display path to show minimal content. Only an explicit clear input or the block reset leaves safe mode.

Top module: `disp_fault_seq`

## Requirements
- R1: After a synchronous reset, the state output is IDLE (6'b000001), the backlight enable is high, and the controller reset, system reset and safe flag are low.
- R2: In IDLE, a fast fault starts the controller recovery in the next cycle. A fast fault is FAST_LIMIT ticks with no qualified frame kick, or the fast-fault input being high. Regular qualified kicks keep the block in IDLE.
- R3: A frame kick with the integrity-ok input low does not restart the fast timeout.
- R4: Controller recovery follows a fixed order. The backlight is off for BL_OFF_TICKS ticks in BL_OFF_WAIT (6'b000010). The controller reset is then high for CTRL_HOLD_TICKS ticks in CTRL_RESET (6'b000100). The backlight stays off for BL_ON_TICKS more ticks in BL_ON_WAIT (6'b001000), and the block then returns to IDLE with the backlight on.
- R5: In IDLE, SLOW_LIMIT ticks with no health kick enter SYS_RESET (6'b010000). There the system reset is high and the backlight is off for CTRL_HOLD_TICKS ticks, after which the block enters BL_ON_WAIT.
- R6: When fast and slow faults are present in the same cycle, the system reset is chosen.
- R7: Each reset the block starts is counted. A fault that arrives with MAX_RESETS resets already counted in the current window enters SAFE (6'b100000) and starts no reset.
- R8: The count clears WINDOW_TICKS ticks after the first reset counted in a window, so a later fault again starts a normal recovery.
- R9: In SAFE, the safe flag and backlight are high and no reset output is asserted, whatever the kicks or faults. Only the clear input leaves SAFE: the block returns to IDLE and the reset count is cleared.
- R10: The state output always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase strobe; all durations count these |
| frame_kick_i | input | 1 | Per-frame activity kick |
| crc_ok_i | input | 1 | Integrity check passed for this frame kick |
| fast_fault_i | input | 1 | External fast-stage fault |
| health_kick_i | input | 1 | Slow-stage health kick |
| safe_clr_i | input | 1 | Leave safe mode |
| bl_en_o | output | 1 | Backlight enable |
| ctrl_rst_o | output | 1 | Display controller reset |
| sys_rst_o | output | 1 | Full-system reset request |
| safe_mode_o | output | 1 | Safe mode flag to the display path |
| state_o | output | 6 | One-hot sequencer state |

## Verification
The bench shrinks every duration. It uses a fast limit of 6 ticks, a slow limit of 40, waits of 4, 3 and 2 ticks, a budget of 3 resets and a 400-tick window. With these values, a run of a few thousand cycles covers repeated recoveries, budget exhaustion, the safe-mode lock, window expiry and a hand-timed collision of fast and slow faults. A behavioural model in the bench follows the ticks and kicks, and the outputs are compared against it on every clock. Part of the run strobes the tick every other cycle, which shows that timeouts count ticks and not clock cycles.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

    typedef enum logic [5:0] {
        ST_IDLE        = 6'b000001,
        ST_BL_OFF_WAIT = 6'b000010,
        ST_CTRL_RESET  = 6'b000100,
        ST_BL_ON_WAIT  = 6'b001000,
        ST_SYS_RESET   = 6'b010000,
        ST_SAFE        = 6'b100000
    } dfr_state_e;

    function automatic int dfr_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // bits needed to hold values 0..n
    function automatic int dfr_cw(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/dfr_kick_timer.sv
module dfr_kick_timer
    import dfr_pkg::*;
#(
    parameter int LIMIT = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic kick,
    output logic expired
);
    localparam int CW = dfr_cw(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en || kick)
            cnt <= '0;
        else if (tick && (cnt != CW'(LIMIT)))
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(LIMIT));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT));

    assert_kick_restarts_R3: assert property (@(posedge clk) disable iff (rst)
        kick |=> !expired);

endmodule

// File: rtl/dfr_reset_budget.sv
module dfr_reset_budget
    import dfr_pkg::*;
#(
    parameter int MAX_RESETS   = 3,
    parameter int WINDOW_TICKS = 60000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic accept,
    input  logic clr,
    output logic full
);
    localparam int NW = dfr_cw(MAX_RESETS);
    localparam int WW = dfr_cw(WINDOW_TICKS);

    logic [NW-1:0] count;
    logic [WW-1:0] win;
    logic          active;
    logic          expire;

    assign active = (count != '0);
    assign expire = active && tick && (win == WW'(WINDOW_TICKS - 1));
    assign full   = (count == NW'(MAX_RESETS)) && !expire;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            win   <= '0;
        end else if (accept) begin
            if (!active || expire) begin
                count <= NW'(1);
                win   <= '0;
            end else begin
                count <= count + 1'b1;
                if (tick)
                    win <= win + 1'b1;
            end
        end else if (expire) begin
            count <= '0;
            win   <= '0;
        end else if (active && tick) begin
            win <= win + 1'b1;
        end
    end

    assert_budget_cap_R7: assert property (@(posedge clk) disable iff (rst)
        count <= NW'(MAX_RESETS));

    assert_window_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (expire && !accept && !clr) |=> (count == '0));

endmodule

// File: rtl/dfr_seq_fsm.sv
module dfr_seq_fsm
    import dfr_pkg::*;
#(
    parameter int BL_OFF_TICKS    = 50,
    parameter int CTRL_HOLD_TICKS = 20,
    parameter int BL_ON_TICKS     = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       fast_fault,
    input  logic       slow_fault,
    input  logic       budget_full,
    input  logic       safe_clr,
    output dfr_state_e state,
    output logic       accept,
    output logic       budget_clr,
    output logic       timers_en
);
    localparam int PH_MAX = dfr_max3(BL_OFF_TICKS, CTRL_HOLD_TICKS, BL_ON_TICKS);
    localparam int PW     = dfr_cw(PH_MAX);

    logic [PW-1:0] phase;
    dfr_state_e    nxt;
    logic          off_done, hold_done, on_done;

    assign off_done  = tick && (phase == PW'(BL_OFF_TICKS - 1));
    assign hold_done = tick && (phase == PW'(CTRL_HOLD_TICKS - 1));
    assign on_done   = tick && (phase == PW'(BL_ON_TICKS - 1));

    always_comb begin
        nxt        = state;
        accept     = 1'b0;
        budget_clr = 1'b0;
        case (state)
            ST_IDLE: begin
                if (fast_fault || slow_fault) begin
                    if (budget_full) begin
                        nxt = ST_SAFE;
                    end else begin
                        accept = 1'b1;
                        nxt    = slow_fault ? ST_SYS_RESET : ST_BL_OFF_WAIT;
                    end
                end
            end
            ST_BL_OFF_WAIT: if (off_done)  nxt = ST_CTRL_RESET;
            ST_CTRL_RESET:  if (hold_done) nxt = ST_BL_ON_WAIT;
            ST_SYS_RESET:   if (hold_done) nxt = ST_BL_ON_WAIT;
            ST_BL_ON_WAIT:  if (on_done)   nxt = ST_IDLE;
            ST_SAFE: begin
                if (safe_clr) begin
                    nxt        = ST_IDLE;
                    budget_clr = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            phase <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)
                phase <= '0;
            else if (tick)
                phase <= phase + 1'b1;
        end
    end

    assign timers_en = (state == ST_IDLE);

    assert_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);

    assert_bl_off_first_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CTRL_RESET && $past(state) != ST_CTRL_RESET)
            |-> ($past(state) == ST_BL_OFF_WAIT));

    assert_sys_priority_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && fast_fault && slow_fault && !budget_full)
            |=> (state == ST_SYS_RESET));

    assert_full_to_safe_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && (fast_fault || slow_fault) && budget_full)
            |=> (state == ST_SAFE));

    assert_safe_latched_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SAFE && !safe_clr) |=> (state == ST_SAFE));

endmodule

// File: rtl/disp_fault_seq.sv
module disp_fault_seq
    import dfr_pkg::*;
#(
    parameter int FAST_LIMIT      = 15,
    parameter int SLOW_LIMIT      = 500,
    parameter int BL_OFF_TICKS    = 50,
    parameter int CTRL_HOLD_TICKS = 20,
    parameter int BL_ON_TICKS     = 10,
    parameter int MAX_RESETS      = 3,
    parameter int WINDOW_TICKS    = 60000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       frame_kick_i,
    input  logic       crc_ok_i,
    input  logic       fast_fault_i,
    input  logic       health_kick_i,
    input  logic       safe_clr_i,
    output logic       bl_en_o,
    output logic       ctrl_rst_o,
    output logic       sys_rst_o,
    output logic       safe_mode_o,
    output logic [5:0] state_o
);
    dfr_state_e state;
    logic timers_en, fast_exp, slow_exp, fast_fault, budget_full, accept, budget_clr;

    dfr_kick_timer #(.LIMIT(FAST_LIMIT)) u_fast (
        .clk(clk), .rst(rst), .en(timers_en), .tick(tick_i),
        .kick(frame_kick_i && crc_ok_i), .expired(fast_exp)
    );

    dfr_kick_timer #(.LIMIT(SLOW_LIMIT)) u_slow (
        .clk(clk), .rst(rst), .en(timers_en), .tick(tick_i),
        .kick(health_kick_i), .expired(slow_exp)
    );

    assign fast_fault = fast_exp || fast_fault_i;

    dfr_reset_budget #(.MAX_RESETS(MAX_RESETS), .WINDOW_TICKS(WINDOW_TICKS)) u_budget (
        .clk(clk), .rst(rst), .tick(tick_i), .accept(accept),
        .clr(budget_clr), .full(budget_full)
    );

    dfr_seq_fsm #(
        .BL_OFF_TICKS(BL_OFF_TICKS), .CTRL_HOLD_TICKS(CTRL_HOLD_TICKS),
        .BL_ON_TICKS(BL_ON_TICKS)
    ) u_fsm (
        .clk(clk), .rst(rst), .tick(tick_i), .fast_fault(fast_fault),
        .slow_fault(slow_exp), .budget_full(budget_full), .safe_clr(safe_clr_i),
        .state(state), .accept(accept), .budget_clr(budget_clr), .timers_en(timers_en)
    );

    assign state_o     = state;
    assign bl_en_o     = (state == ST_IDLE) || (state == ST_SAFE);
    assign ctrl_rst_o  = (state == ST_CTRL_RESET);
    assign sys_rst_o   = (state == ST_SYS_RESET);
    assign safe_mode_o = (state == ST_SAFE);

    assert_no_reset_in_safe_R9: assert property (@(posedge clk) disable iff (rst)
        safe_mode_o |-> (!ctrl_rst_o && !sys_rst_o && bl_en_o));

endmodule

// File: tb/disp_fault_seq_tb_top.sv
module disp_fault_seq_tb_top;
    localparam int FL = 6, SL = 40, BOFF = 4, HOLD = 3, BON = 2, MAXR = 3, WIN = 400;
    localparam logic [5:0] S_IDLE = 6'b000001, S_BOFF = 6'b000010, S_CTRL = 6'b000100,
                           S_BON = 6'b001000, S_SYS = 6'b010000, S_SAFE = 6'b100000;

    logic clk = 1'b0, rst = 1'b1;
    logic tick_i = 1'b0, frame_kick_i = 1'b0, crc_ok_i = 1'b1, fast_fault_i = 1'b0;
    logic health_kick_i = 1'b0, safe_clr_i = 1'b0;
    logic bl_en_o, ctrl_rst_o, sys_rst_o, safe_mode_o;
    logic [5:0] state_o;

    always #10 clk = ~clk;

    disp_fault_seq #(
        .FAST_LIMIT(FL), .SLOW_LIMIT(SL), .BL_OFF_TICKS(BOFF), .CTRL_HOLD_TICKS(HOLD),
        .BL_ON_TICKS(BON), .MAX_RESETS(MAXR), .WINDOW_TICKS(WIN)
    ) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .frame_kick_i(frame_kick_i),
        .crc_ok_i(crc_ok_i), .fast_fault_i(fast_fault_i), .health_kick_i(health_kick_i),
        .safe_clr_i(safe_clr_i), .bl_en_o(bl_en_o), .ctrl_rst_o(ctrl_rst_o),
        .sys_rst_o(sys_rst_o), .safe_mode_o(safe_mode_o), .state_o(state_o)
    );

    int n_chk = 0, n_fail = 0;
    int ctrl_cnt = 0, bloff_cnt = 0, sys_cnt = 0;
    bit auto_frame = 0, auto_health = 0, bad_crc = 0, tick_half = 0, done = 0;
    int cyc_n = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // stimulus pattern generator
    always @(negedge clk) begin
        cyc_n++;
        tick_i        <= tick_half ? cyc_n[0] : 1'b1;
        frame_kick_i  <= auto_frame && (cyc_n % 3 == 0);
        crc_ok_i      <= !bad_crc;
        health_kick_i <= auto_health && (cyc_n % 10 == 0);
    end

    // behavioural reference model
    logic [5:0] ms;
    int mph, mf, msl, mc, mw;
    always @(posedge clk) begin
        if (rst) begin
            ms = S_IDLE; mph = 0; mf = 0; msl = 0; mc = 0; mw = 0;
        end else begin
            logic [5:0] ns;
            bit acc, clr, wexp, full, ff, sf;
            ff   = (mf == FL) || fast_fault_i;
            sf   = (msl == SL);
            wexp = (mc > 0) && tick_i && (mw == WIN - 1);
            full = (mc == MAXR) && !wexp;
            ns = ms; acc = 0; clr = 0;
            case (ms)
                S_IDLE: if (ff || sf) begin
                    if (full) ns = S_SAFE;
                    else begin acc = 1; ns = sf ? S_SYS : S_BOFF; end
                end
                S_BOFF: if (tick_i && mph == BOFF - 1) ns = S_CTRL;
                S_CTRL: if (tick_i && mph == HOLD - 1) ns = S_BON;
                S_SYS:  if (tick_i && mph == HOLD - 1) ns = S_BON;
                S_BON:  if (tick_i && mph == BON - 1)  ns = S_IDLE;
                S_SAFE: if (safe_clr_i) begin ns = S_IDLE; clr = 1; end
                default: ns = S_IDLE;
            endcase
            if (ms != S_IDLE || (frame_kick_i && crc_ok_i)) mf = 0;
            else if (tick_i && mf < FL) mf++;
            if (ms != S_IDLE || health_kick_i) msl = 0;
            else if (tick_i && msl < SL) msl++;
            if (clr) begin mc = 0; mw = 0; end
            else if (acc) begin
                if (mc == 0 || wexp) begin mc = 1; mw = 0; end
                else begin mc++; if (tick_i) mw++; end
            end else if (wexp) begin mc = 0; mw = 0; end
            else if (mc > 0 && tick_i) mw++;
            if (ns != ms) mph = 0; else if (tick_i) mph++;
            ms = ns;
        end
    end

    // per-cycle comparison and output monitors
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R10 state", state_o, ms);
            chk("R4 backlight", bl_en_o, (ms == S_IDLE || ms == S_SAFE));
            chk("R4 ctrl reset", ctrl_rst_o, (ms == S_CTRL));
            chk("R5 sys reset", sys_rst_o, (ms == S_SYS));
            chk("R9 safe flag", safe_mode_o, (ms == S_SAFE));
            if (ctrl_rst_o) ctrl_cnt++;
            if (!bl_en_o)   bloff_cnt++;
            if (sys_rst_o)  sys_cnt++;
        end
    end

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic watch_for(input logic [5:0] st, input int n, output bit seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (state_o == st) begin seen = 1; break; end
        end
    endtask

    task automatic until_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (state_o == S_IDLE) break;
        end
    endtask

    task automatic pulse_fast();
        @(negedge clk); fast_fault_i = 1'b1;
        @(negedge clk); fast_fault_i = 1'b0;
    endtask

    initial begin
        bit seen;
        int c0, b0, s0;
        cyc(4);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 state", state_o, S_IDLE);
        chk("R1 backlight", bl_en_o, 1);
        chk("R1 ctrl reset", ctrl_rst_o, 0);
        chk("R1 sys reset", sys_rst_o, 0);
        chk("R1 safe flag", safe_mode_o, 0);

        // R2: healthy kicks with a half-rate tick keep IDLE
        auto_frame = 1; auto_health = 1; tick_half = 1;
        cyc(100);
        chk("R2 no false fault", state_o, S_IDLE);
        tick_half = 0;
        cyc(5);

        // R3: kicks without integrity ok are ignored
        c0 = ctrl_cnt; b0 = bloff_cnt;
        bad_crc = 1;
        watch_for(S_BOFF, 30, seen);
        chk("R3 unqualified kick ignored", seen, 1);
        bad_crc = 0;
        until_idle();
        chk("R4 ctrl reset length", ctrl_cnt - c0, HOLD);
        chk("R4 backlight off length", bloff_cnt - b0, BOFF + HOLD + BON);
        cyc(20);

        // R2: external fast fault
        c0 = ctrl_cnt;
        pulse_fast();
        watch_for(S_BOFF, 3, seen);
        chk("R2 external fast fault", seen, 1);
        until_idle();
        chk("R2 controller reset issued", ctrl_cnt - c0, HOLD);
        cyc(20);

        // R5: missing health kick
        c0 = ctrl_cnt; s0 = sys_cnt;
        auto_health = 0;
        watch_for(S_SYS, 80, seen);
        chk("R5 slow timeout", seen, 1);
        auto_health = 1;
        until_idle();
        chk("R5 sys reset length", sys_cnt - s0, HOLD);
        chk("R5 no controller reset", ctrl_cnt - c0, 0);
        cyc(20);

        // R7: fourth fault inside the window
        c0 = ctrl_cnt; s0 = sys_cnt;
        pulse_fast();
        watch_for(S_SAFE, 3, seen);
        chk("R7 budget exhausted to safe", seen, 1);

        // R9: safe mode ignores everything
        auto_frame = 0; auto_health = 0;
        pulse_fast();
        cyc(100);
        chk("R9 stays safe", state_o, S_SAFE);
        chk("R9 safe flag", safe_mode_o, 1);
        chk("R9 backlight on", bl_en_o, 1);
        chk("R9 no ctrl reset", ctrl_cnt - c0, 0);
        chk("R9 no sys reset", sys_cnt - s0, 0);
        auto_frame = 1; auto_health = 1;
        cyc(12);
        @(negedge clk); safe_clr_i = 1'b1;
        @(negedge clk); safe_clr_i = 1'b0;
        chk("R9 clear leaves safe", state_o, S_IDLE);

        // R9/R8: count cleared, three recoveries allowed
        for (int k = 0; k < 3; k++) begin
            pulse_fast();
            watch_for(S_BOFF, 3, seen);
            chk("R9 count cleared on exit", seen, 1);
            until_idle();
            cyc(5);
        end

        // R8: window expiry restores the budget
        cyc(450);
        pulse_fast();
        watch_for(S_BOFF, 3, seen);
        chk("R8 window expiry", seen, 1);

        // R6: fast and slow faults in the same cycle
        auto_health = 0;
        until_idle();
        cyc(40);
        fast_fault_i = 1'b1;
        @(negedge clk); fast_fault_i = 1'b0;
        chk("R6 system reset wins", state_o, S_SYS);
        auto_health = 1;
        until_idle();
        cyc(10);
        finish_run();
    end
endmodule